// File: doc/BRIEF.md
# Video Controller Host Write Port

This block sits between a host processor and the memories of a tile-based video controller. The host has two ports, selected by one select line. The address port takes a destination word, and a read of the same port returns the controller's status word. The data port takes words for memory. The destination word picks main video RAM or one of two small auxiliary RAMs, and it also gives the starting offset inside the chosen memory.

Words written to the data port go into a buffer that holds exactly one word. A second write before the memory side has taken the first one replaces it. The memory side sees a request whenever a word is waiting and the destination is legal. When it acknowledges, the word is consumed and the offset moves on to the next location. The offset therefore advances when a word is pulled from the buffer, not when the host writes it. Loading a new destination throws away any word that is still waiting.

Top module: `vdp_host_port`

## Requirements
- R1: After reset, `fifo_full` and `mem_req` are 0, `mem_target` is 0 (main RAM), `mem_offset` is 0 and `host_rdata` is 0.
- R2: An address-port write of a word whose bit 15 is 0 sets `mem_target` to 0 and `mem_offset` to bits 14:0, visible the cycle after the write.
- R3: An address-port write with bit 15 set and bits 14:8 equal to 0x7E sets `mem_target` to 1. With bits 14:8 equal to 0x7F it sets `mem_target` to 2. In both cases `mem_offset` is bits 7:0 with bit 0 forced to 0 and bits 14:8 zero.
- R4: An address-port write with bit 15 set and any other code in bits 14:8 sets `mem_target` to 3. While the target is 3, `mem_req` stays 0, even when a word is buffered, and acknowledges change nothing.
- R5: A data-port write sets `fifo_full` to 1 and presents the word on `mem_wdata` the next cycle. For a legal target, `mem_req` is 1 in that same cycle.
- R6: A data-port write while `fifo_full` is 1 replaces the buffered word and leaves `mem_offset` unchanged.
- R7: When `mem_req` and `mem_ack` are both 1 in a cycle, the buffered word is consumed and `fifo_full` clears, unless a new data write arrives in that cycle. For target 0 the offset then adds 1, wrapping 0x7FFF to 0. For targets 1 and 2 it adds 2 within 8 bits, wrapping 0xFE to 0.
- R8: `mem_ack` while `mem_req` is 0 leaves `mem_offset` and `fifo_full` unchanged.
- R9: An address-port write clears `fifo_full` and `mem_req` in the next cycle, which discards the waiting word.
- R10: An address-port read puts `status_in` onto `host_rdata` the next cycle. A data-port read leaves `host_rdata`, `fifo_full` and `mem_offset` unchanged.
- R11: A data write in the same cycle as an accepted acknowledge leaves `fifo_full` at 1 with the new word, and the offset advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address port, 1 = data port |
| host_wdata | input | 16 | Host write data |
| status_in | input | 16 | Status word returned by address-port reads |
| host_rdata | output | 16 | Registered read data |
| mem_ack | input | 1 | Memory side takes the buffered word |
| mem_req | output | 1 | A word is waiting for a legal target |
| mem_target | output | 2 | 0 main RAM, 1 and 2 auxiliary RAMs, 3 illegal |
| mem_offset | output | 15 | Current offset in the selected memory |
| mem_wdata | output | 16 | Buffered word |
| fifo_full | output | 1 | Buffer holds a word |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 15-bit main-RAM offset and 8-bit auxiliary offsets. With these widths, both wrap points (0x7FFF and 0xFE) can be reached by a single address write followed by one pull. Codes 0x7E and 0x7F and one illegal code can all be driven directly, so every target value is reached, along with overwrite, discard on reload and the same-cycle write-and-pull case.

// File: rtl/vdp_host_pkg.sv
package vdp_host_pkg;
  typedef enum logic [1:0] {
    TGT_MAIN = 2'd0,
    TGT_AUXA = 2'd1,
    TGT_AUXB = 2'd2,
    TGT_BAD  = 2'd3
  } tgt_e;
endpackage

// File: rtl/vdp_dest_decode.sv
module vdp_dest_decode
  import vdp_host_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int AUX_AW    = 8,
  parameter logic [DATA_W-AUX_AW-2:0] AUXA_CODE = 7'h7E,
  parameter logic [DATA_W-AUX_AW-2:0] AUXB_CODE = 7'h7F
) (
  input  logic [DATA_W-1:0] word,
  output tgt_e              tgt,
  output logic [DATA_W-2:0] off
);
  localparam int MAIN_AW = DATA_W - 1;
  localparam int CODE_W  = DATA_W - 1 - AUX_AW;

  logic [CODE_W-1:0] code;
  assign code = word[DATA_W-2 -: CODE_W];

  always_comb begin
    off = '0;
    if (!word[DATA_W-1]) begin
      tgt = TGT_MAIN;
      off = word[MAIN_AW-1:0];
    end else begin
      // auxiliary offsets are byte offsets kept word aligned
      off[AUX_AW-1:0] = {word[AUX_AW-1:1], 1'b0};
      if (code == AUXA_CODE)      tgt = TGT_AUXA;
      else if (code == AUXB_CODE) tgt = TGT_AUXB;
      else                        tgt = TGT_BAD;
    end
  end
endmodule

// File: rtl/vdp_offset_ctr.sv
module vdp_offset_ctr
  import vdp_host_pkg::*;
#(
  parameter int OFF_W  = 15,
  parameter int AUX_AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] load_val,
  input  tgt_e             tgt,
  input  logic             step,
  output logic [OFF_W-1:0] off
);
  localparam logic [AUX_AW-1:0] AUX_STEP = AUX_AW'(2);

  logic [OFF_W-1:0] off_next;
  logic [AUX_AW-1:0] aux_sum;

  assign aux_sum = off[AUX_AW-1:0] + AUX_STEP;

  always_comb begin
    off_next = off;
    if (load) begin
      off_next = load_val;
    end else if (step) begin
      if (tgt == TGT_MAIN) begin
        off_next = off + OFF_W'(1);
      end else begin
        off_next = '0;
        off_next[AUX_AW-1:0] = aux_sum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) off <= '0;
    else     off <= off_next;
  end
endmodule

// File: rtl/vdp_word_buf.sv
module vdp_word_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr) data <= wdata;
      if (flush)    full <= 1'b0;
      else if (wr)  full <= 1'b1;
      else if (pop) full <= 1'b0;
    end
  end
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
  import vdp_host_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AUX_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_strobe,
  input  logic              host_write,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [1:0]        mem_target,
  output logic [DATA_W-2:0] mem_offset,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fifo_full
);
  localparam int OFF_W = DATA_W - 1;

  logic dest_wr, data_wr, stat_rd, pop;
  tgt_e dec_tgt, tgt_q;
  logic [OFF_W-1:0] dec_off;

  assign dest_wr = host_strobe &  host_write & ~host_sel;
  assign data_wr = host_strobe &  host_write &  host_sel;
  assign stat_rd = host_strobe & ~host_write & ~host_sel;
  assign pop     = mem_req & mem_ack & ~dest_wr;

  vdp_dest_decode #(.DATA_W(DATA_W), .AUX_AW(AUX_AW)) u_dec (
    .word (host_wdata),
    .tgt  (dec_tgt),
    .off  (dec_off)
  );

  always_ff @(posedge clk) begin
    if (rst)          tgt_q <= TGT_MAIN;
    else if (dest_wr) tgt_q <= dec_tgt;
  end

  vdp_offset_ctr #(.OFF_W(OFF_W), .AUX_AW(AUX_AW)) u_off (
    .clk      (clk),
    .rst      (rst),
    .load     (dest_wr),
    .load_val (dec_off),
    .tgt      (tgt_q),
    .step     (pop),
    .off      (mem_offset)
  );

  vdp_word_buf #(.DATA_W(DATA_W)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .flush (dest_wr),
    .wr    (data_wr),
    .wdata (host_wdata),
    .pop   (pop),
    .full  (fifo_full),
    .data  (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (stat_rd) host_rdata <= status_in;
  end

  assign mem_req    = fifo_full & (tgt_q != TGT_BAD);
  assign mem_target = tgt_q;
endmodule

// File: rtl/vdp_host_port_chk.sv
module vdp_host_port_chk #(
  parameter int DATA_W = 16,
  parameter int AUX_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_strobe,
  input logic              host_write,
  input logic              host_sel,
  input logic              mem_ack,
  input logic              mem_req,
  input logic [1:0]        mem_target,
  input logic [DATA_W-2:0] mem_offset,
  input logic              fifo_full
);
  logic dwr, awr;
  assign dwr = host_strobe & host_write & host_sel;
  assign awr = host_strobe & host_write & ~host_sel;

  assert_write_fills_R5: assert property (@(posedge clk) disable iff (rst)
    dwr |=> fifo_full);

  assert_bad_no_req_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_target == 2'd3) |-> !mem_req);

  assert_reload_discards_R9: assert property (@(posedge clk) disable iff (rst)
    awr |=> (!fifo_full && !mem_req));

  assert_overwrite_holds_off_R6: assert property (@(posedge clk) disable iff (rst)
    (dwr && !mem_ack) |=> $stable(mem_offset));

  assert_idle_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_ack && !mem_req && !host_strobe) |=> ($stable(mem_offset) && $stable(fifo_full)));

  assert_pull_moves_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !awr) |=> !$stable(mem_offset));
endmodule

bind vdp_host_port vdp_host_port_chk #(.DATA_W(DATA_W), .AUX_AW(AUX_AW)) u_chk (.*);

// File: tb/vdp_host_port_tb.sv
module vdp_host_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_strobe = 1'b0, host_write = 1'b0, host_sel = 1'b0;
  logic [15:0] host_wdata = '0, status_in = '0;
  logic [15:0] host_rdata;
  logic        mem_ack = 1'b0;
  logic        mem_req;
  logic [1:0]  mem_target;
  logic [14:0] mem_offset;
  logic [15:0] mem_wdata;
  logic        fifo_full;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdp_host_port u_dut (
    .clk, .rst, .host_strobe, .host_write, .host_sel, .host_wdata,
    .status_in, .host_rdata, .mem_ack, .mem_req, .mem_target,
    .mem_offset, .mem_wdata, .fifo_full
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive for one cycle starting at a falling edge; return at the next falling edge
  task automatic host_op(bit wr, bit sel, logic [15:0] d, bit ack);
    @(negedge clk);
    host_strobe = 1'b1; host_write = wr; host_sel = sel; host_wdata = d; mem_ack = ack;
    @(negedge clk);
    host_strobe = 1'b0; host_write = 1'b0; host_sel = 1'b0; mem_ack = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "full", fifo_full, 0);
    chk("R1", "req", mem_req, 0);
    chk("R1", "target", mem_target, 0);
    chk("R1", "offset", mem_offset, 0);
    chk("R1", "rdata", host_rdata, 0);
  endtask

  task automatic t_main();
    host_op(1, 0, 16'h1234, 0);
    chk("R2", "target", mem_target, 0);
    chk("R2", "offset", mem_offset, 'h1234);
    host_op(1, 1, 16'hAAAA, 0);
    chk("R5", "full", fifo_full, 1);
    chk("R5", "req", mem_req, 1);
    chk("R5", "wdata", mem_wdata, 'hAAAA);
    ack_pulse();
    chk("R7", "full after pull", fifo_full, 0);
    chk("R7", "offset after pull", mem_offset, 'h1235);
  endtask

  task automatic t_overwrite();
    host_op(1, 1, 16'h1111, 0);
    host_op(1, 1, 16'h2222, 0);
    chk("R6", "wdata", mem_wdata, 'h2222);
    chk("R6", "offset held", mem_offset, 'h1235);
    ack_pulse();
    chk("R6", "single advance", mem_offset, 'h1236);
  endtask

  task automatic t_idle_ack();
    ack_pulse();
    chk("R8", "offset", mem_offset, 'h1236);
    chk("R8", "full", fifo_full, 0);
  endtask

  task automatic t_main_wrap();
    host_op(1, 0, 16'h7FFF, 0);
    host_op(1, 1, 16'h0001, 0);
    ack_pulse();
    chk("R7", "main wrap", mem_offset, 0);
  endtask

  task automatic t_aux();
    host_op(1, 0, 16'hFE13, 0);
    chk("R3", "target A", mem_target, 1);
    chk("R3", "offset lsb cleared", mem_offset, 'h12);
    host_op(1, 1, 16'h0002, 0);
    ack_pulse();
    chk("R7", "aux step", mem_offset, 'h14);
    host_op(1, 0, 16'hFFFF, 0);
    chk("R3", "target B", mem_target, 2);
    chk("R3", "offset B", mem_offset, 'hFE);
    host_op(1, 1, 16'h0003, 0);
    ack_pulse();
    chk("R7", "aux wrap", mem_offset, 0);
  endtask

  task automatic t_bad();
    host_op(1, 0, 16'h8005, 0);
    chk("R4", "target", mem_target, 3);
    chk("R4", "offset", mem_offset, 'h04);
    host_op(1, 1, 16'h0BAD, 0);
    chk("R4", "full", fifo_full, 1);
    chk("R4", "req", mem_req, 0);
    ack_pulse();
    chk("R4", "offset after ack", mem_offset, 'h04);
    chk("R4", "full after ack", fifo_full, 1);
  endtask

  task automatic t_flush();
    host_op(1, 0, 16'h0010, 0);
    host_op(1, 1, 16'h7777, 0);
    host_op(1, 0, 16'h0020, 0);
    chk("R9", "full", fifo_full, 0);
    chk("R9", "req", mem_req, 0);
    chk("R9", "offset", mem_offset, 'h20);
  endtask

  task automatic t_status();
    status_in = 16'hBEEF;
    host_op(0, 0, 16'h0000, 0);
    chk("R10", "status read", host_rdata, 'hBEEF);
    status_in = 16'h1357;
    host_op(0, 1, 16'h0000, 0);
    chk("R10", "data read rdata", host_rdata, 'hBEEF);
    chk("R10", "data read full", fifo_full, 0);
    chk("R10", "data read offset", mem_offset, 'h20);
  endtask

  task automatic t_simul();
    host_op(1, 0, 16'h0100, 0);
    host_op(1, 1, 16'h5555, 0);
    host_op(1, 1, 16'h6666, 1);
    chk("R11", "full", fifo_full, 1);
    chk("R11", "wdata", mem_wdata, 'h6666);
    chk("R11", "offset", mem_offset, 'h101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_main();
    t_overwrite();
    t_idle_ack();
    t_main_wrap();
    t_aux();
    t_bad();
    t_flush();
    t_status();
    t_simul();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule